// File: doc/BRIEF.md
# Multiplexed Fetch Bus Interface

This block runs the external program-fetch bus cycle for a small microcontroller core whose memory port shares the low address byte and the returned data on a single 8-bit lane. When the core presents a fetch address, the block opens a machine cycle of six states, each two oscillator clocks long. It places the full address on the pins and pulses the address latch enable, so that an external transparent latch holds A0–A7 when that enable falls. It then releases the shared lane, waits one state for the external decoders to settle, and pulls the program-read strobe low. The byte is captured at the final clock of the strobe and returned to the core as a single-cycle response.

The high address byte has its own lane and is held for the whole cycle. Three selects are produced from the held address. The ROM select is active low and follows A13 = 0, covering 0000h–1FFFh. The RAM select is active high and follows A13 = 1, covering 2000h–3FFFh. The peripheral select is active low when A13 = 0 and the program-read strobe is inactive, so a peripheral never answers during a ROM fetch. A2:A1 choose one of the peripheral's four registers. The core sees a ready/valid request interface and a valid-only response.

Top module: `xfetch_bus`

## Requirements
- R1: While reset is held and right after its release: req_ready = 1, adr_latch_en = 0, prog_rd_n = 1, bus_lo_oe = 0, rsp_valid = 0, rom_sel_n = 1, ram_sel = 0, per_sel_n = 1.
- R2: Counting the clock after acceptance as phase 0, adr_latch_en is high in phases 0–2 and low in phases 3–11. The lane drives A7:A0 with bus_lo_oe = 1 in phases 0–3, so a latch on the falling enable holds the low address byte.
- R3: bus_hi carries A15:A8 of the accepted address in all twelve phases, even if req_addr changes during the cycle.
- R4: bus_lo_oe is 0 in phases 4–11, covering the decode state and the read.
- R5: prog_rd_n is low in phases 6–9 only, and is never low while adr_latch_en is high.
- R6: The returned byte is the value of bus_lo_in during phase 9, the last clock of the strobe. rsp_valid is high for exactly one clock, in phase 10, with that byte on rsp_data.
- R7: During a cycle, rom_sel_n = 0 for every phase when A13 = 0, and ram_sel = 1 for every phase when A13 = 1. Outside a cycle, rom_sel_n = 1 and ram_sel = 0.
- R8: During a cycle with A13 = 0, per_sel_n is low exactly in the phases where prog_rd_n is high. With A13 = 1, per_sel_n stays high. per_reg equals A2:A1 throughout the cycle.
- R9: req_ready is 0 in phases 0–11. A request held valid during that time is not taken until the cycle ends, and req_ready is 1 in the clock after phase 11.
- R10: With req_valid held high, successive acceptances are 13 clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Core presents a fetch address |
| req_addr | input | 16 | Fetch address |
| req_ready | output | 1 | Block is idle and takes the request on this edge |
| rsp_valid | output | 1 | One-clock pulse with the fetched byte |
| rsp_data | output | 8 | Fetched byte |
| bus_lo_out | output | 8 | Low address byte driven onto the shared lane |
| bus_lo_oe | output | 1 | Output enable of the shared lane |
| bus_lo_in | input | 8 | Value read back from the shared lane |
| bus_hi | output | 8 | High address byte lane |
| adr_latch_en | output | 1 | Address latch enable; the external latch closes on its falling edge |
| prog_rd_n | output | 1 | Active-low program-read strobe |
| rom_sel_n | output | 1 | Active-low ROM select |
| ram_sel | output | 1 | Active-high RAM select |
| per_sel_n | output | 1 | Active-low peripheral select |
| per_reg | output | 2 | Peripheral register index (A2:A1) |

## Verification
The hardest behaviour to reach from the pins is the exact capture point. The byte has to be taken on the last strobe clock and not on any earlier one, yet a memory that drives valid data for the whole strobe would accept either. The bench memory therefore counts how many clocks the strobe has been low, and it drives the correct byte only in the fourth such clock, with a filler value before that. Any earlier capture returns the filler. The second corner is an address that changes under a held request. The bench swaps req_addr right after acceptance and checks that the high lane, the latched low byte and the selects still follow the first address until the following acceptance.

// File: rtl/xfb_pkg.sv
package xfb_pkg;
  // States per machine cycle of the fetch bus
  localparam int unsigned STATES_PER_CYC = 6;

  // Strobe bundle handed from the strobe generator to the pins
  typedef struct packed {
    logic latch_en;
    logic rd_n;
    logic lo_oe;
  } xfb_strobe_t;
endpackage

// File: rtl/xfb_seq.sv
module xfb_seq #(
  parameter int ADDR_W = 16,
  parameter int PH_W   = 4,
  parameter int LAST   = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              busy_q,
  output logic              busy_d,
  output logic [PH_W-1:0]   phase_d,
  output logic [ADDR_W-1:0] addr_q
);
  localparam logic [PH_W-1:0] LAST_P = PH_W'(LAST);

  logic [PH_W-1:0]   phase_q;
  logic              accept;
  logic              addr_en;

  assign req_ready = ~busy_q;
  assign accept    = req_valid & ~busy_q;
  assign addr_en   = accept;

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    if (accept) begin
      busy_d  = 1'b1;
      phase_d = '0;
    end else if (busy_q) begin
      if (phase_q == LAST_P) begin
        busy_d  = 1'b0;
        phase_d = '0;
      end else begin
        phase_d = PH_W'(phase_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= req_addr;
    end
  end

  // R9: once a cycle starts it runs to its last phase
  a_r9_cycle_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (phase_q != LAST_P)) |=> busy_q);

  // R3: the held address does not move inside a cycle
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && busy_d) |=> $stable(addr_q));
endmodule

// File: rtl/xfb_strobe.sv
module xfb_strobe
  import xfb_pkg::*;
#(
  parameter int CPS  = 2,
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy_d,
  input  logic [PH_W-1:0] phase_d,
  output xfb_strobe_t     strb_q,
  output logic            sample_q
);
  // Phase boundaries derived from the state length
  localparam logic [PH_W-1:0] LATCH_END = PH_W'(CPS + CPS / 2);
  localparam logic [PH_W-1:0] ADDR_END  = PH_W'(2 * CPS);
  localparam logic [PH_W-1:0] RD_BEG    = PH_W'(3 * CPS);
  localparam logic [PH_W-1:0] RD_END    = PH_W'(5 * CPS);
  localparam logic [PH_W-1:0] RD_LAST   = PH_W'(5 * CPS - 1);

  xfb_strobe_t strb_d;
  logic        sample_d;

  always_comb begin
    strb_d.latch_en = busy_d && (phase_d < LATCH_END);
    strb_d.lo_oe    = busy_d && (phase_d < ADDR_END);
    strb_d.rd_n     = !(busy_d && (phase_d >= RD_BEG) && (phase_d < RD_END));
    sample_d        = busy_d && (phase_d == RD_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q   <= '{latch_en: 1'b0, rd_n: 1'b1, lo_oe: 1'b0};
      sample_q <= 1'b0;
    end else begin
      strb_q   <= strb_d;
      sample_q <= sample_d;
    end
  end

  // R5: strobe only after the latch enable has fallen
  a_r5_rd_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb_q.latch_en && !strb_q.rd_n));

  // R4: lane released while the read strobe is active
  a_r4_lane_free_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_q.rd_n |-> !strb_q.lo_oe);

  // R6: capture point lies inside the strobe
  a_r6_sample_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sample_q |-> !strb_q.rd_n);
endmodule

// File: rtl/xfb_capture.sv
module xfb_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] lane_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= sample_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data <= '0;
    end else if (sample_en) begin
      rsp_data <= lane_in;
    end
  end

  // R6: response is a single-clock pulse
  a_r6_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R6: response follows a clock with the strobe active
  a_r6_rsp_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!rd_n));
endmodule

// File: rtl/xfb_decode.sv
module xfb_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       a_sel,
  input  logic [1:0] a_reg,
  input  logic       rd_n,
  output logic       rom_sel_n,
  output logic       ram_sel,
  output logic       per_sel_n,
  output logic [1:0] per_reg
);
  always_comb begin
    rom_sel_n = !(busy && !a_sel);
    ram_sel   = busy && a_sel;
    per_sel_n = !(busy && !a_sel && rd_n);
    per_reg   = a_reg;
  end

  // R7: ROM and RAM never selected together
  a_r7_rom_ram_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_sel_n && ram_sel));

  // R8: peripheral is off while the program strobe is active
  a_r8_per_off_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !per_sel_n |-> rd_n);
endmodule

// File: rtl/xfetch_bus.sv
module xfetch_bus
  import xfb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int CPS     = 2,
  parameter int SEL_BIT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] bus_lo_out,
  output logic              bus_lo_oe,
  input  logic [DATA_W-1:0] bus_lo_in,
  output logic [ADDR_W-DATA_W-1:0] bus_hi,
  output logic              adr_latch_en,
  output logic              prog_rd_n,
  output logic              rom_sel_n,
  output logic              ram_sel,
  output logic              per_sel_n,
  output logic [1:0]        per_reg
);
  localparam int CYC_CLKS = int'(STATES_PER_CYC) * CPS;
  localparam int PH_W     = $clog2(CYC_CLKS);
  localparam int HI_W     = ADDR_W - DATA_W;

  // Reset: asserted at once, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic              busy_q;
  logic              busy_d;
  logic [PH_W-1:0]   phase_d;
  logic [ADDR_W-1:0] addr_q;
  xfb_strobe_t       strb;
  logic              sample;

  xfb_seq #(.ADDR_W(ADDR_W), .PH_W(PH_W), .LAST(CYC_CLKS - 1)) seq_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .busy_q    (busy_q),
    .busy_d    (busy_d),
    .phase_d   (phase_d),
    .addr_q    (addr_q)
  );

  xfb_strobe #(.CPS(CPS), .PH_W(PH_W)) strobe_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .busy_d   (busy_d),
    .phase_d  (phase_d),
    .strb_q   (strb),
    .sample_q (sample)
  );

  xfb_capture #(.DATA_W(DATA_W)) capture_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sample_en (sample),
    .rd_n      (strb.rd_n),
    .lane_in   (bus_lo_in),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  xfb_decode decode_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .busy      (busy_q),
    .a_sel     (addr_q[SEL_BIT]),
    .a_reg     (addr_q[2:1]),
    .rd_n      (strb.rd_n),
    .rom_sel_n (rom_sel_n),
    .ram_sel   (ram_sel),
    .per_sel_n (per_sel_n),
    .per_reg   (per_reg)
  );

  assign bus_lo_out   = addr_q[DATA_W-1:0];
  assign bus_lo_oe    = strb.lo_oe;
  assign bus_hi       = busy_q ? addr_q[ADDR_W-1:DATA_W] : {HI_W{1'b1}};
  assign adr_latch_en = strb.latch_en;
  assign prog_rd_n    = strb.rd_n;

  // R2: lane driven when the latch enable falls
  a_r2_addr_at_latch: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(adr_latch_en) |-> bus_lo_oe);
endmodule

// File: tb/xfetch_bus_tb_top.sv
module xfetch_bus_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_addr;
  logic        req_ready;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [7:0]  bus_lo_out;
  logic        bus_lo_oe;
  logic [7:0]  bus_lo_in;
  logic [7:0]  bus_hi;
  logic        adr_latch_en;
  logic        prog_rd_n;
  logic        rom_sel_n;
  logic        ram_sel;
  logic        per_sel_n;
  logic [1:0]  per_reg;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  xfetch_bus dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_lo_out(bus_lo_out), .bus_lo_oe(bus_lo_oe), .bus_lo_in(bus_lo_in),
    .bus_hi(bus_hi), .adr_latch_en(adr_latch_en), .prog_rd_n(prog_rd_n),
    .rom_sel_n(rom_sel_n), .ram_sel(ram_sel), .per_sel_n(per_sel_n),
    .per_reg(per_reg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // External latch and memories
  logic [7:0] lat_lo;
  logic       lat_oe;
  int         rd_cnt;

  always @(negedge adr_latch_en) begin
    lat_lo <= bus_lo_out;
    lat_oe <= bus_lo_oe;
  end

  always @(posedge clk) begin
    if (!prog_rd_n) rd_cnt <= rd_cnt + 1;
    else            rd_cnt <= 0;
  end

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  function automatic logic [7:0] ram_byte(input logic [15:0] a);
    return ~a[7:0] + {2'b00, a[13:8]};
  endfunction

  // Slow memory: valid only in the fourth strobe clock
  always_comb begin
    bus_lo_in = 8'hEE;
    if (!prog_rd_n && rd_cnt >= 3) begin
      if (!rom_sel_n)   bus_lo_in = rom_byte({bus_hi, lat_lo});
      else if (ram_sel) bus_lo_in = ram_byte({bus_hi, lat_lo});
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  time acc_t;

  // One fetch with a per-phase record of every pin
  task automatic run_fetch(input logic [15:0] a, input bit keep, input logic [15:0] nxt);
    logic [11:0] v_le, v_rd, v_oe, v_rsp, v_rdy, v_rom, v_ram, v_per;
    bit          hi_ok, reg_ok;
    logic [7:0]  got;
    logic [7:0]  want;
    req_addr  = a;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    acc_t = $time;
    @(negedge clk);
    if (keep) req_addr = nxt;
    else      req_valid = 1'b0;
    hi_ok = 1; reg_ok = 1; got = 8'h00;
    for (int k = 0; k < 12; k++) begin
      if (k > 0) @(negedge clk);
      v_le[k]  = adr_latch_en;
      v_rd[k]  = prog_rd_n;
      v_oe[k]  = bus_lo_oe;
      v_rsp[k] = rsp_valid;
      v_rdy[k] = req_ready;
      v_rom[k] = rom_sel_n;
      v_ram[k] = ram_sel;
      v_per[k] = per_sel_n;
      if (bus_hi !== a[15:8]) hi_ok = 0;
      if (per_reg !== a[2:1]) reg_ok = 0;
      if (rsp_valid) got = rsp_data;
    end
    want = a[13] ? ram_byte(a) : rom_byte(a);
    chk("R2 latch enable phases", 32'(v_le), 32'h007);
    chk("R2 latched low byte", {23'd0, lat_oe, lat_lo}, {23'd0, 1'b1, a[7:0]});
    chk("R3 high lane held", 32'(hi_ok), 32'd1);
    chk("R4 lane enable phases", 32'(v_oe), 32'h00F);
    chk("R5 strobe phases", 32'(v_rd), 32'hC3F);
    chk("R6 response phase", 32'(v_rsp), 32'h400);
    chk("R6 response byte", 32'(got), 32'(want));
    chk("R7 rom select", 32'(v_rom), a[13] ? 32'hFFF : 32'h000);
    chk("R7 ram select", 32'(v_ram), a[13] ? 32'hFFF : 32'h000);
    chk("R8 peripheral select", 32'(v_per), a[13] ? 32'hFFF : 32'h3C0);
    chk("R8 peripheral register", 32'(reg_ok), 32'd1);
    chk("R9 ready low in cycle", 32'(v_rdy), 32'h000);
    @(negedge clk);
    chk("R9 ready after cycle", 32'(req_ready), 32'd1);
  endtask

  task automatic test_reset();
    req_valid = 1'b0;
    req_addr  = 16'h0000;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 idle pins in reset",
        {24'd0, req_ready, adr_latch_en, prog_rd_n, bus_lo_oe, rsp_valid, rom_sel_n, ram_sel, per_sel_n},
        {24'd0, 8'b1010_0101});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle pins after release",
        {24'd0, req_ready, adr_latch_en, prog_rd_n, bus_lo_oe, rsp_valid, rom_sel_n, ram_sel, per_sel_n},
        {24'd0, 8'b1010_0101});
  endtask

  task automatic test_rom_ram();
    run_fetch(16'h0123, 0, 16'h0);
    run_fetch(16'h2A56, 0, 16'h0);
    run_fetch(16'h1FFF, 0, 16'h0);
    run_fetch(16'h2000, 0, 16'h0);
    run_fetch(16'h00F6, 0, 16'h0);
  endtask

  task automatic test_back_to_back();
    time t0;
    repeat (3) @(negedge clk);
    run_fetch(16'h0B1C, 1, 16'h3D42);
    t0 = acc_t;
    run_fetch(16'h3D42, 0, 16'h0);
    chk("R10 accept spacing in clocks", 32'((acc_t - t0) / 4), 32'd13);
    chk("R9 idle after last", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_rom_ram();
    test_back_to_back();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule